// File: doc/BRIEF.md
# Reset Cause Status Register

This block records why the system last went through a reset and keeps that reason in a 5-bit status word that a host can read at any time. Five sources can start a reset: power-on, a front-panel request, a remote-console request, a pulse that resets only the PCI buses, and a host write that sets the trigger bit (bit 0). On each rising clock edge the block picks the source with the highest priority, if any, and updates the status word. It also issues a one-cycle full-system reset request or a PCI-bus reset request.

The parameter `STICKY_LAYOUT` selects one of two encodings. With the value 0 the block uses the legacy layout. In that layout exactly one cause bit is set, and power-on and PCI resets share a single marker bit. With the value 1 the block uses the newer layout. There, power-on clears the whole word and the marker bit is never used. Once the software bit is set it survives every later reset except power-on. A PCI reset clears the front-panel and remote-console bits but records nothing of its own.

Top module: `rst_cause_reg`

## Requirements
- R1: The status word `rd_data_o` places the bits as follows. Bit 4 is remote-console reset, bit 3 is front-panel reset, bit 2 is the power-on/PCI marker and bit 1 is software reset. Bit 0 is a write-only trigger and always reads 0.
- R2: A cycle with `wr_en_i`=1 and `wr_data_i[0]`=1 is a software reset request. A write whose bit 0 is 0 changes nothing, whatever the other data bits are.
- R3: In legacy mode (`STICKY_LAYOUT`=0) the status reads 00010 after a software reset and 00100 after a power-on or PCI reset. It reads 01000 after a front-panel reset and 10000 after a remote-console reset.
- R4: In sticky mode (`STICKY_LAYOUT`=1) the status reads 00000 after power-on, and bit 2 is never set.
- R5: In sticky mode, a software reset sets the status to 00010. After that, bit 1 stays set through every later front-panel, remote-console, PCI or software reset until a power-on. A front-panel reset therefore reads 01010 and a remote-console reset reads 10010 when bit 1 was set.
- R6: In sticky mode a PCI reset clears bits 4 and 3 and keeps bit 1 unchanged.
- R7: `sys_rst_req_o` is 1 for exactly the one cycle after a front-panel, remote-console or software reset wins. `pci_rst_req_o` is 1 for exactly the one cycle after a PCI reset wins. The two outputs are never 1 together, and neither responds to power-on.
- R8: The status changes at the first rising edge at which a source is sampled. It holds its value while no source is asserted.
- R9: When several sources are sampled at the same edge, the highest-priority one decides the result. Power-on is highest, then remote console, then front panel, then software write, then PCI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sources are sampled on its rising edge |
| por_i | input | 1 | Power-on reset, active high, synchronous |
| fp_rst_i | input | 1 | Front-panel reset request |
| rc_rst_i | input | 1 | Remote-console reset request |
| pci_rst_i | input | 1 | PCI-only reset pulse |
| wr_en_i | input | 1 | Host write strobe for the status register |
| wr_data_i | input | 5 | Host write data; only bit 0 (the trigger) has an effect |
| rd_data_o | output | 5 | Status word, bit 0 reads 0 |
| sys_rst_req_o | output | 1 | One-cycle full-system reset request |
| pci_rst_req_o | output | 1 | One-cycle PCI-bus reset request |

## Verification
Every result sits one register stage behind its inputs. The status word and both request outputs are due at the first rising edge after the inputs are applied. The bench drives inputs on a falling edge and compares all three results at the next falling edge, then clears the inputs. One idle cycle later it checks again that the status held and that both requests returned to 0. Every combination of the five sources is applied after every combination as the prior state, so sticky-bit carry-over and priority are each seen from every starting word.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

    localparam int STAT_W   = 5;
    localparam int BIT_TRIG = 0;
    localparam int BIT_SW   = 1;
    localparam int BIT_MARK = 2;
    localparam int BIT_FP   = 3;
    localparam int BIT_RC   = 4;

    typedef enum logic [2:0] {
        CAUSE_NONE,
        CAUSE_POR,
        CAUSE_RC,
        CAUSE_FP,
        CAUSE_SW,
        CAUSE_PCI
    } cause_e;

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic              sys_req;
        logic              pci_req;
    } rcr_state_t;

endpackage

// File: rtl/rcr_arbiter.sv
module rcr_arbiter
    import rcr_pkg::*;
(
    input  logic   por,
    input  logic   rc_req,
    input  logic   fp_req,
    input  logic   sw_req,
    input  logic   pci_req,
    output cause_e cause
);

    // Fixed priority: power-on, remote console, front panel, software, PCI (R9)
    always_comb begin
        if (por)          cause = CAUSE_POR;
        else if (rc_req)  cause = CAUSE_RC;
        else if (fp_req)  cause = CAUSE_FP;
        else if (sw_req)  cause = CAUSE_SW;
        else if (pci_req) cause = CAUSE_PCI;
        else              cause = CAUSE_NONE;
    end

endmodule

// File: rtl/rcr_encoder.sv
module rcr_encoder
    import rcr_pkg::*;
#(
    parameter bit STICKY_LAYOUT = 1'b1
) (
    input  cause_e            cause,
    input  logic [STAT_W-1:0] cur,
    output logic [STAT_W-1:0] nxt
);

    generate
        if (STICKY_LAYOUT) begin : g_sticky
            logic keep_sw;
            assign keep_sw = cur[BIT_SW];
            always_comb begin
                nxt = cur;
                case (cause)
                    CAUSE_POR: nxt = '0;
                    CAUSE_RC: begin
                        nxt = '0;
                        nxt[BIT_RC] = 1'b1;
                        nxt[BIT_SW] = keep_sw;
                    end
                    CAUSE_FP: begin
                        nxt = '0;
                        nxt[BIT_FP] = 1'b1;
                        nxt[BIT_SW] = keep_sw;
                    end
                    CAUSE_SW: begin
                        nxt = '0;
                        nxt[BIT_SW] = 1'b1;
                    end
                    CAUSE_PCI: begin
                        nxt = '0;
                        nxt[BIT_SW] = keep_sw;
                    end
                    default: nxt = cur;
                endcase
                nxt[BIT_TRIG] = 1'b0;
            end
        end else begin : g_legacy
            always_comb begin
                nxt = cur;
                case (cause)
                    CAUSE_POR, CAUSE_PCI: begin
                        nxt = '0;
                        nxt[BIT_MARK] = 1'b1;
                    end
                    CAUSE_RC: begin
                        nxt = '0;
                        nxt[BIT_RC] = 1'b1;
                    end
                    CAUSE_FP: begin
                        nxt = '0;
                        nxt[BIT_FP] = 1'b1;
                    end
                    CAUSE_SW: begin
                        nxt = '0;
                        nxt[BIT_SW] = 1'b1;
                    end
                    default: nxt = cur;
                endcase
                nxt[BIT_TRIG] = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
    import rcr_pkg::*;
#(
    parameter bit STICKY_LAYOUT = 1'b1
) (
    input  logic              clk,
    input  logic              por_i,
    input  logic              fp_rst_i,
    input  logic              rc_rst_i,
    input  logic              pci_rst_i,
    input  logic              wr_en_i,
    input  logic [STAT_W-1:0] wr_data_i,
    output logic [STAT_W-1:0] rd_data_o,
    output logic              sys_rst_req_o,
    output logic              pci_rst_req_o
);

    cause_e            cause;
    logic              sw_trig;
    logic [STAT_W-1:0] status_nxt;
    logic              unused_wr_bits;
    rcr_state_t        st_d;
    rcr_state_t        st_q;

    // Only the trigger bit of a write matters (R2)
    assign sw_trig        = wr_en_i & wr_data_i[BIT_TRIG];
    assign unused_wr_bits = ^wr_data_i[STAT_W-1:BIT_TRIG+1];

    rcr_arbiter u_arb (
        .por     (por_i),
        .rc_req  (rc_rst_i),
        .fp_req  (fp_rst_i),
        .sw_req  (sw_trig),
        .pci_req (pci_rst_i),
        .cause   (cause)
    );

    rcr_encoder #(
        .STICKY_LAYOUT (STICKY_LAYOUT)
    ) u_enc (
        .cause (cause),
        .cur   (st_q.status),
        .nxt   (status_nxt)
    );

    always_comb begin
        st_d         = st_q;
        st_d.status  = status_nxt;
        st_d.sys_req = (cause == CAUSE_RC) || (cause == CAUSE_FP) || (cause == CAUSE_SW);
        st_d.pci_req = (cause == CAUSE_PCI);
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_data_o     = {st_q.status[STAT_W-1:BIT_TRIG+1], 1'b0};
    assign sys_rst_req_o = st_q.sys_req;
    assign pci_rst_req_o = st_q.pci_req;

    // R7: the two requests are exclusive
    p_req_exclusive_r7: assert property (@(posedge clk) disable iff (por_i)
        !(sys_rst_req_o && pci_rst_req_o));

    // R8: with no source asserted the status holds
    p_hold_r8: assert property (@(posedge clk) disable iff (por_i)
        !(fp_rst_i || rc_rst_i || pci_rst_i || sw_trig) |=> $stable(rd_data_o));

    // R9: remote console beats front panel
    p_rc_over_fp_r9: assert property (@(posedge clk) disable iff (por_i)
        rc_rst_i |=> (rd_data_o[BIT_RC] && !rd_data_o[BIT_FP]));

    // R7: a PCI-only pulse never requests a system reset
    p_pci_only_r7: assert property (@(posedge clk) disable iff (por_i)
        (pci_rst_i && !rc_rst_i && !fp_rst_i && !sw_trig) |=> (pci_rst_req_o && !sys_rst_req_o));

    generate
        if (STICKY_LAYOUT) begin : g_chk_sticky
            // R5: software bit stays set until power-on
            p_sw_sticky_r5: assert property (@(posedge clk) disable iff (por_i)
                rd_data_o[BIT_SW] |=> rd_data_o[BIT_SW]);
            // R4: marker bit never set in sticky layout
            p_no_marker_r4: assert property (@(posedge clk) disable iff (por_i)
                !rd_data_o[BIT_MARK]);
        end else begin : g_chk_legacy
            // R3: legacy status is one-hot
            p_onehot_r3: assert property (@(posedge clk) disable iff (por_i)
                $onehot0(rd_data_o));
        end
    endgenerate

endmodule

// File: tb/rst_cause_reg_tb.sv
module rst_cause_reg_tb;

    logic       clk = 1'b0;
    logic       por, fp, rc, pci, wen;
    logic [4:0] wdata;
    logic [4:0] rd_s, rd_l;
    logic       sys_s, sys_l, preq_s, preq_l;
    int         n_chk  = 0;
    int         n_fail = 0;
    bit         done   = 0;
    logic [4:0] exp_s, exp_l;

    always #10 clk = ~clk;

    rst_cause_reg #(.STICKY_LAYOUT(1'b1)) u_dut (
        .clk(clk), .por_i(por), .fp_rst_i(fp), .rc_rst_i(rc), .pci_rst_i(pci),
        .wr_en_i(wen), .wr_data_i(wdata),
        .rd_data_o(rd_s), .sys_rst_req_o(sys_s), .pci_rst_req_o(preq_s)
    );

    rst_cause_reg #(.STICKY_LAYOUT(1'b0)) u_dut_legacy (
        .clk(clk), .por_i(por), .fp_rst_i(fp), .rc_rst_i(rc), .pci_rst_i(pci),
        .wr_en_i(wen), .wr_data_i(wdata),
        .rd_data_o(rd_l), .sys_rst_req_o(sys_l), .pci_rst_req_o(preq_l)
    );

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, expv, $time);
        end
    endtask

    // Expected result from the requirements: {status, sys_req, pci_req}
    function automatic logic [6:0] model(input bit sticky, input logic [4:0] prev,
                                         input logic [4:0] v);
        logic [4:0] s;
        logic       sy, pq;
        s = prev; sy = 1'b0; pq = 1'b0;
        if (v[0]) s = sticky ? 5'b00000 : 5'b00100;
        else if (v[1]) begin s = sticky ? {4'b1000, 1'b0} | {3'b000, prev[1], 1'b0} : 5'b10000; sy = 1'b1; end
        else if (v[2]) begin s = sticky ? {4'b0100, 1'b0} | {3'b000, prev[1], 1'b0} : 5'b01000; sy = 1'b1; end
        else if (v[3]) begin s = 5'b00010; sy = 1'b1; end
        else if (v[4]) begin s = sticky ? {3'b000, prev[1], 1'b0} : 5'b00100; pq = 1'b1; end
        return {s, sy, pq};
    endfunction

    // v = {pci, sw, fp, rc, por}; called at a falling edge
    task automatic apply(input logic [4:0] v);
        logic [6:0] ms, ml;
        string      ts, tl, tr;
        por = v[0]; rc = v[1]; fp = v[2]; wen = 1'b1; wdata = {4'b1111, v[3]}; pci = v[4];
        ms = model(1'b1, exp_s, v);
        ml = model(1'b0, exp_l, v);
        if ($countones(v) > 1)        begin ts = "R9"; tl = "R9"; end
        else if (v[0])                begin ts = "R4"; tl = "R3"; end
        else if (v[4])                begin ts = "R6"; tl = "R3"; end
        else                          begin ts = "R5"; tl = "R3"; end
        tr = (v == 5'b01000) ? "R2" : ((v == 5'b00000) ? "R2" : "R7");
        @(posedge clk);
        @(negedge clk);
        chk(ts, rd_s, ms[6:2]);
        chk(tl, rd_l, ml[6:2]);
        chk(tr, {3'b0, sys_s, preq_s}, {3'b0, ms[1:0]});
        chk(tr, {3'b0, sys_l, preq_l}, {3'b0, ml[1:0]});
        chk("R1", {4'b0, rd_s[0] | rd_l[0]}, 5'b0);
        exp_s = ms[6:2];
        exp_l = ml[6:2];
        por = 1'b0; rc = 1'b0; fp = 1'b0; pci = 1'b0; wen = 1'b0; wdata = 5'b0;
    endtask

    task automatic idle();
        @(posedge clk);
        @(negedge clk);
        chk("R8", rd_s, exp_s);
        chk("R8", rd_l, exp_l);
        chk("R7", {3'b0, sys_s, preq_s, sys_l} , 5'b0);
        chk("R7", {4'b0, preq_l}, 5'b0);
    endtask

    initial begin
        por = 1'b1; rc = 1'b0; fp = 1'b0; pci = 1'b0; wen = 1'b0; wdata = 5'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R4", rd_s, 5'b00000);
        chk("R3", rd_l, 5'b00100);
        chk("R7", {3'b0, sys_s, preq_s}, 5'b0);
        exp_s = 5'b00000;
        exp_l = 5'b00100;
        por = 1'b0;
        idle();
        // Specific sticky sequence: software, then front panel reads 01010 (R5)
        apply(5'b01000);
        apply(5'b00100);
        chk("R5", rd_s, 5'b01010);
        idle();
        // Sweep every prior pattern against every new pattern
        for (int p = 0; p < 32; p++) begin
            for (int c = 0; c < 32; c++) begin
                apply(p[4:0]);
                apply(c[4:0]);
                idle();
            end
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule